// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings one switchable logic domain up or down in a fixed, safe order. It drives the domain's control lines: reset release, isolation, a two-stage power switch enable, a clock gate and a group of memory power-down lines. It listens to two power-good status inputs, to a per-bank memory acknowledge, and to an external bus-protection unit that it reaches through a request/acknowledge pair.

Software talks to it over a small write bus. First it writes an unlock key. After that it can issue on or off commands and change the wait timeout. Status is visible on output pins: busy, done, a sticky timeout error and a sticky overrun flag. Each control step takes exactly one clock. Every wait has a cycle limit, so a domain that never answers leaves the outputs frozen and the error raised instead of hanging the sequencer.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset the control word `ctl_word` reads 0xF12. This means release=0 (bit 0), isolation=1 (bit 1), first switch=0 (bit 2), second switch=0 (bit 3), clock-disable=1 (bit 4) and memory power-down=1111 (bits 11:8). Also `bp_req` is 1, and busy, done, err_tmo and err_ovr are all 0.
- R2: Writes to address 1 (command) and address 2 (timeout) take effect only while the block is unlocked. The block becomes unlocked after a write to address 0 whose bits 31:16 equal 0x0B16 and whose bit 0 is 1. Any other write to address 0 locks the block again.
- R3: A command write with bit 0 set starts power-up. The steps are, in order: set the first switch, set the second switch, wait on status, clear clock-disable, clear isolation, set release, clear the memory power-down bits.
- R4: Power-up leaves its status wait only when both status inputs are 1. If only one of them is 1, the wait continues.
- R5: After clearing the memory power-down bits, power-up waits until every acknowledge bit inside the mask reads 0. Only then does it drop `bp_req`, as its last step. It reports done once `bp_ack` reads 0.
- R6: A command write with bit 1 set and bit 0 clear starts power-down. The steps are, in order:
  - raise `bp_req` and wait for `bp_ack`;
  - set the memory power-down bits and wait until every masked acknowledge bit reads 1;
  - set isolation, clear release, set clock-disable, clear the first switch, clear the second switch.
- R7: Power-down reports done only after both status inputs read 0.
- R8: At most one control step takes effect per clock. The steps are the individual bits 0 to 4, the memory field as a whole, and `bp_req`.
- R9: If a wait lasts longer than the programmed limit (address 2, bits 15:0), the sequencer goes idle with err_tmo set and done clear. All control outputs then hold their values.
- R10: A command written while busy is ignored and sets err_ovr. The next command that is accepted clears err_ovr, and also clears done and err_tmo.
- R11: Acknowledge bits outside the ACK_MASK parameter (default 0011) have no effect on either acknowledge wait.
- R12: A command with both bit 0 and bit 1 set is taken as power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Write address: 0 key, 1 command, 2 timeout |
| bus_wdata | input | 32 | Write data |
| pg_st1 | input | 1 | First power-good status |
| pg_st2 | input | 1 | Second power-good status |
| mem_ack | input | MEM_W | Memory power-down acknowledge per bank |
| bp_ack | input | 1 | Bus protection acknowledge |
| ctl_word | output | 8+MEM_W | Domain control lines (layout as in R1) |
| bp_req | output | 1 | Bus protection request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed |
| err_tmo | output | 1 | Sticky wait timeout |
| err_ovr | output | 1 | Sticky command overrun |

## Verification
Two events can meet in a single cycle: a command being accepted and the sequencer still being busy from the previous command. The bench provokes this by writing an off command and an on command on consecutive cycles. It then judges the outcome by the final control word, which must match the first command only, and by the overrun flag. A second collision lies between a status wait that cannot finish and the timeout counter reaching its limit. The bench holds one status input low under a short limit and checks that the error rises and that the partial control word stays frozen.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int B_REL  = 0;
  localparam int B_ISO  = 1;
  localparam int B_PON  = 2;
  localparam int B_PON2 = 3;
  localparam int B_CLKD = 4;
  localparam int MEM_LO = 8;
  localparam logic [15:0] UNLOCK_KEY = 16'h0B16;

  typedef enum logic [4:0] {
    S_IDLE,
    U_PON, U_PON2, U_WPG, U_CLK, U_ISO, U_REL, U_MEM, U_WACK, U_BP, U_WBP,
    D_BP, D_WBP, D_MEM, D_WACK, D_ISO, D_REL, D_CLK, D_PON, D_PON2, D_WPG
  } seq_state_e;
endpackage

// File: rtl/pds_regif.sv
module pds_regif import pds_pkg::*; #(
  parameter int TMO_W   = 16,
  parameter int TMO_RST = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             busy,
  output logic             cmd_on,
  output logic             cmd_off,
  output logic [TMO_W-1:0] tmo_lim,
  output logic             err_ovr
);
  logic             unlk_q, unlk_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             ovr_q, ovr_d;
  logic             cmd_acc, key_wr, tmo_wr;

  always_comb begin
    key_wr  = bus_wr && (bus_addr == 2'd0);
    tmo_wr  = bus_wr && (bus_addr == 2'd2) && unlk_q;
    cmd_acc = bus_wr && (bus_addr == 2'd1) && unlk_q && (bus_wdata[0] || bus_wdata[1]);
    cmd_on  = cmd_acc && !busy && bus_wdata[0];
    cmd_off = cmd_acc && !busy && !bus_wdata[0] && bus_wdata[1];
    unlk_d  = key_wr ? ((bus_wdata[31:16] == UNLOCK_KEY) && bus_wdata[0]) : unlk_q;
    tmo_d   = tmo_wr ? bus_wdata[TMO_W-1:0] : tmo_q;
    ovr_d   = ovr_q;
    if (cmd_acc) ovr_d = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlk_q <= 1'b0;
      tmo_q  <= TMO_W'(TMO_RST);
      ovr_q  <= 1'b0;
    end else begin
      unlk_q <= unlk_d;
      if (tmo_wr) tmo_q <= tmo_d;
      ovr_q  <= ovr_d;
    end
  end

  assign tmo_lim = tmo_q;
  assign err_ovr = ovr_q;

  // R10
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == 2'd1 && unlk_q && (|bus_wdata[1:0])) |=> err_ovr);
endmodule

// File: rtl/pds_wtimer.sv
module pds_wtimer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] lim,
  output logic             expired
);
  logic [TMO_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d   = run ? (cnt_q + 1'b1) : '0;
    expired = run && (cnt_q >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm import pds_pkg::*; #(
  parameter int               MEM_W    = 4,
  parameter logic [MEM_W-1:0] ACK_MASK = 4'b0011,
  parameter bit               USE_BP   = 1'b1,
  localparam int              CTL_W    = 8 + MEM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_on,
  input  logic             cmd_off,
  input  logic             pg1,
  input  logic             pg2,
  input  logic [MEM_W-1:0] mem_ack,
  input  logic             bp_ack,
  input  logic             expired,
  output logic [CTL_W-1:0] ctl_word,
  output logic             bp_req,
  output logic             busy,
  output logic             done,
  output logic             err_tmo,
  output logic             wait_st
);
  localparam logic [CTL_W-1:0] CTL_RST = {{MEM_W{1'b1}}, 3'b000, 5'b10010};

  seq_state_e       st_q, st_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             bp_q, bp_d, done_q, done_d, err_q, err_d;
  logic             ack_clr, ack_all;

  always_comb begin
    ack_clr = (mem_ack & ACK_MASK) == '0;
    ack_all = (mem_ack & ACK_MASK) == ACK_MASK;
    st_d    = st_q;
    ctl_d   = ctl_q;
    bp_d    = bp_q;
    done_d  = done_q;
    err_d   = err_q;
    wait_st = (st_q == U_WPG) || (st_q == U_WACK) || (st_q == U_WBP) ||
              (st_q == D_WBP) || (st_q == D_WACK) || (st_q == D_WPG);
    case (st_q)
      S_IDLE: begin
        if (cmd_on || cmd_off) begin
          done_d = 1'b0;
          err_d  = 1'b0;
          st_d   = cmd_on ? U_PON : (USE_BP ? D_BP : D_MEM);
        end
      end
      U_PON:  begin ctl_d[B_PON]  = 1'b1; st_d = U_PON2; end
      U_PON2: begin ctl_d[B_PON2] = 1'b1; st_d = U_WPG;  end
      U_WPG: begin
        if (pg1 && pg2) st_d = U_CLK;
        else if (expired) begin err_d = 1'b1; st_d = S_IDLE; end
      end
      U_CLK: begin ctl_d[B_CLKD] = 1'b0; st_d = U_ISO; end
      U_ISO: begin ctl_d[B_ISO]  = 1'b0; st_d = U_REL; end
      U_REL: begin ctl_d[B_REL]  = 1'b1; st_d = U_MEM; end
      U_MEM: begin ctl_d[CTL_W-1:MEM_LO] = '0; st_d = U_WACK; end
      U_WACK: begin
        if (ack_clr) begin
          if (USE_BP) st_d = U_BP;
          else begin done_d = 1'b1; st_d = S_IDLE; end
        end else if (expired) begin err_d = 1'b1; st_d = S_IDLE; end
      end
      U_BP: begin bp_d = 1'b0; st_d = U_WBP; end
      U_WBP: begin
        if (!bp_ack) begin done_d = 1'b1; st_d = S_IDLE; end
        else if (expired) begin err_d = 1'b1; st_d = S_IDLE; end
      end
      D_BP: begin bp_d = 1'b1; st_d = D_WBP; end
      D_WBP: begin
        if (bp_ack) st_d = D_MEM;
        else if (expired) begin err_d = 1'b1; st_d = S_IDLE; end
      end
      D_MEM: begin ctl_d[CTL_W-1:MEM_LO] = '1; st_d = D_WACK; end
      D_WACK: begin
        if (ack_all) st_d = D_ISO;
        else if (expired) begin err_d = 1'b1; st_d = S_IDLE; end
      end
      D_ISO:  begin ctl_d[B_ISO]  = 1'b1; st_d = D_REL;  end
      D_REL:  begin ctl_d[B_REL]  = 1'b0; st_d = D_CLK;  end
      D_CLK:  begin ctl_d[B_CLKD] = 1'b1; st_d = D_PON;  end
      D_PON:  begin ctl_d[B_PON]  = 1'b0; st_d = D_PON2; end
      D_PON2: begin ctl_d[B_PON2] = 1'b0; st_d = D_WPG;  end
      D_WPG: begin
        if (!pg1 && !pg2) begin done_d = 1'b1; st_d = S_IDLE; end
        else if (expired) begin err_d = 1'b1; st_d = S_IDLE; end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ctl_q  <= CTL_RST;
      bp_q   <= USE_BP;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ctl_q  <= ctl_d;
      bp_q   <= bp_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign ctl_word = ctl_q;
  assign bp_req   = bp_q;
  assign busy     = st_q != S_IDLE;
  assign done     = done_q;
  assign err_tmo  = err_q;

  // R8
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctl_q[4:0] ^ $past(ctl_q[4:0]),
                |(ctl_q[CTL_W-1:MEM_LO] ^ $past(ctl_q[CTL_W-1:MEM_LO])),
                bp_q ^ $past(bp_q)}) <= 1);
  // R4
  clk_after_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[B_CLKD]) |-> $past(pg1 && pg2, 2));
  // R5
  bp_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bp_q) |-> ($past((mem_ack & ACK_MASK) == '0, 2) && ctl_q[B_REL]));
  // R6
  iso_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[B_ISO]) |-> $past((mem_ack & ACK_MASK) == ACK_MASK, 2));
  // R7
  off_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_q) && !ctl_q[B_PON2]) |-> $past(!pg1 && !pg2));
  // R9
  tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && st_q == S_IDLE) |=> ($stable(ctl_q) && $stable(bp_q)));
endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq #(
  parameter int               MEM_W    = 4,
  parameter logic [MEM_W-1:0] ACK_MASK = 4'b0011,
  parameter bit               USE_BP   = 1'b1,
  parameter int               TMO_W    = 16,
  parameter int               TMO_RST  = 200,
  localparam int              CTL_W    = 8 + MEM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             pg_st1,
  input  logic             pg_st2,
  input  logic [MEM_W-1:0] mem_ack,
  input  logic             bp_ack,
  output logic [CTL_W-1:0] ctl_word,
  output logic             bp_req,
  output logic             busy,
  output logic             done,
  output logic             err_tmo,
  output logic             err_ovr
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             cmd_on, cmd_off, wait_st, expired;
  logic [TMO_W-1:0] tmo_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pds_regif #(.TMO_W(TMO_W), .TMO_RST(TMO_RST)) u_regif (
    .clk(clk), .rst_n(rst_int_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .tmo_lim(tmo_lim), .err_ovr(err_ovr));

  pds_wtimer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .run(wait_st), .lim(tmo_lim), .expired(expired));

  pds_fsm #(.MEM_W(MEM_W), .ACK_MASK(ACK_MASK), .USE_BP(USE_BP)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .pg1(pg_st1), .pg2(pg_st2), .mem_ack(mem_ack), .bp_ack(bp_ack),
    .expired(expired), .ctl_word(ctl_word), .bp_req(bp_req), .busy(busy),
    .done(done), .err_tmo(err_tmo), .wait_st(wait_st));
endmodule

// File: tb/pwr_dom_seq_tb.sv
module pwr_dom_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        pg_st1, pg_st2, bp_ack;
  logic [3:0]  mem_ack;
  logic [11:0] ctl_word;
  logic        bp_req, busy, done, err_tmo, err_ovr;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pwr_dom_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pg_st1(pg_st1), .pg_st2(pg_st2), .mem_ack(mem_ack),
    .bp_ack(bp_ack), .ctl_word(ctl_word), .bp_req(bp_req), .busy(busy),
    .done(done), .err_tmo(err_tmo), .err_ovr(err_ovr));

  // domain model: delayed responses plus forcing knobs
  logic [7:0] sh_on, sh_on2, sh_bp;
  logic [3:0] sh_mem [8];
  logic [2:0] pg_dly, ack_dly;
  logic [3:0] ack_force;
  logic       hold0, hold1;

  always @(posedge clk) begin
    sh_on  <= {sh_on[6:0], ctl_word[2]};
    sh_on2 <= {sh_on2[6:0], ctl_word[3]};
    sh_bp  <= {sh_bp[6:0], bp_req};
    sh_mem[0] <= ctl_word[11:8];
    for (int i = 1; i < 8; i++) sh_mem[i] <= sh_mem[i-1];
  end

  assign pg_st1  = hold1 | sh_on[pg_dly];
  assign pg_st2  = hold1 | (~hold0 & sh_on2[pg_dly]);
  assign mem_ack = sh_mem[ack_dly] | ack_force;
  assign bp_ack  = sh_bp[1];

  // step log: 1 on1, 2 on2, 3 clk, 4 iso, 5 rel, 6 mem, 7 bp
  logic [11:0] prev_c;
  logic        prev_b, multi;
  logic [27:0] seq_pk;
  int          log_n, run_id = 0, seen_id = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      prev_c = ctl_word; prev_b = bp_req; log_n = 0; multi = 1'b0; seq_pk = '0;
    end else begin
      logic [6:0] ch;
      if (run_id != seen_id) begin
        seen_id = run_id; log_n = 0; multi = 1'b0; seq_pk = '0;
      end
      ch = {bp_req ^ prev_b, |(ctl_word[11:8] ^ prev_c[11:8]),
            ctl_word[0] ^ prev_c[0], ctl_word[1] ^ prev_c[1],
            ctl_word[4] ^ prev_c[4], ctl_word[3] ^ prev_c[3], ctl_word[2] ^ prev_c[2]};
      if ($countones(ch) > 1) multi = 1'b1;
      for (int k = 0; k < 7; k++)
        if (ch[k] && $countones(ch) == 1) begin
          seq_pk = {seq_pk[23:0], 4'(k + 1)};
          log_n++;
        end
      prev_c = ctl_word; prev_b = bp_req;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] c);
    run_id++;
    wr(2'd1, {30'd0, c});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  // {cmd[20:19], pg_dly[18:16], ack_dly[15:13], exp_ctl[12:1], exp_bp[0]}
  localparam logic [20:0] VEC [6] = '{
    {2'b01, 3'd1, 3'd1, 12'h00D, 1'b0},
    {2'b10, 3'd2, 3'd2, 12'hF12, 1'b1},
    {2'b01, 3'd4, 3'd0, 12'h00D, 1'b0},
    {2'b10, 3'd0, 3'd3, 12'hF12, 1'b1},
    {2'b11, 3'd6, 3'd5, 12'h00D, 1'b0},  // R12 both bits -> up
    {2'b10, 3'd7, 3'd7, 12'hF12, 1'b1}
  };
  localparam logic [27:0] UP_SEQ = 28'h1234567;
  localparam logic [27:0] DN_SEQ = 28'h7645312;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1..: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pg_dly = 3'd1; ack_dly = 3'd1; ack_force = '0; hold0 = 1'b0; hold1 = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(ctl_word == 12'hF12 && bp_req, "R1 reset ctl/bp", {bp_req, ctl_word}, 32'h1F12);
    chk({busy, done, err_tmo, err_ovr} == 4'b0, "R1 reset status",
        {busy, done, err_tmo, err_ovr}, 0);

    cmd(2'b01); repeat (20) @(negedge clk);
    chk(!busy && ctl_word == 12'hF12, "R2 locked cmd ignored", {busy, ctl_word}, 32'hF12);
    wr(2'd0, 32'h0B17_0001); cmd(2'b01); repeat (20) @(negedge clk);
    chk(!busy && ctl_word == 12'hF12, "R2 wrong key", {busy, ctl_word}, 32'hF12);
    wr(2'd0, 32'h0B16_0000); cmd(2'b01); repeat (20) @(negedge clk);
    chk(!busy && ctl_word == 12'hF12, "R2 key bit0 clear", {busy, ctl_word}, 32'hF12);
    wr(2'd0, 32'h0B16_0001);

    for (int v = 0; v < 6; v++) begin
      logic [20:0] e;
      e = VEC[v];
      pg_dly = e[18:16]; ack_dly = e[15:13];
      cmd(e[20:19]);
      wait_idle();
      @(negedge clk);
      chk(ctl_word == e[12:1] && bp_req == e[0] && done && !err_tmo,
          e[19] ? "R3/R5 up final state" : "R6/R7 down final state",
          {done, bp_req, ctl_word}, {1'b1, e[0], e[12:1]});
      chk(log_n == 7 && seq_pk == (e[19] ? UP_SEQ : DN_SEQ),
          e[19] ? "R3/R5 up step order" : "R6 down step order",
          {log_n[3:0], seq_pk}, {4'd7, e[19] ? UP_SEQ : DN_SEQ});
      chk(!multi, "R8 one step per clock", multi, 0);
    end
    pg_dly = 3'd1; ack_dly = 3'd1;

    // R11: bits outside mask held high do not block power-up
    ack_force = 4'b1100; cmd(2'b01); wait_idle();
    chk(done && ctl_word == 12'h00D, "R11 masked-out ack ignored", {done, ctl_word}, 32'h100D);
    cmd(2'b10); wait_idle(); ack_force = '0;
    chk(done && ctl_word == 12'hF12, "R11 down with masked-out ack", {done, ctl_word}, 32'h1F12);

    // R5: ack held -> bus protection not released
    ack_force = 4'b0001; cmd(2'b01); repeat (30) @(negedge clk);
    chk(busy && bp_req && ctl_word[11:8] == 4'h0, "R5 bp held while ack pending",
        {busy, bp_req, ctl_word}, 32'h3000);
    ack_force = '0; wait_idle();
    chk(done && !bp_req, "R5 bp released last", {done, bp_req}, 2'b10);

    // R7: status held high keeps power-down open
    hold1 = 1'b1; cmd(2'b10); repeat (30) @(negedge clk);
    chk(busy && !done && ctl_word[3:2] == 2'b00, "R7 down waits status low",
        {busy, done, ctl_word}, 32'h2F12);
    hold1 = 1'b0; wait_idle();
    chk(done && ctl_word == 12'hF12, "R7 down completes", {done, ctl_word}, 32'h1F12);

    // R4: mismatched status keeps power-up waiting
    hold0 = 1'b1; cmd(2'b01); repeat (30) @(negedge clk);
    chk(busy && ctl_word == 12'hF1E, "R4 mismatch keeps waiting", {busy, ctl_word}, 32'h1F1E);
    hold0 = 1'b0; wait_idle();
    chk(done && ctl_word == 12'h00D, "R4 both status high", {done, ctl_word}, 32'h100D);

    // R10: back-to-back commands
    cmd(2'b10); cmd(2'b01); wait_idle();
    chk(ctl_word == 12'hF12 && err_ovr, "R10 busy cmd ignored", {err_ovr, ctl_word}, 32'h1F12);
    cmd(2'b01); wait_idle();
    chk(!err_ovr && ctl_word == 12'h00D, "R10 overrun cleared", {err_ovr, ctl_word}, 32'h00D);
    cmd(2'b10); wait_idle();

    // R9: timeout on status wait
    wr(2'd2, 32'd10);
    hold0 = 1'b1; cmd(2'b01); wait_idle();
    chk(err_tmo && !busy && !done && ctl_word == 12'hF1E, "R9 timeout raises error",
        {err_tmo, busy, done, ctl_word}, 32'h4F1E);
    repeat (10) @(negedge clk);
    chk(ctl_word == 12'hF1E && bp_req && err_tmo, "R9 outputs held",
        {err_tmo, bp_req, ctl_word}, 32'h3F1E);

    summary();
    $finish;
  end
endmodule